// File: doc/BRIEF.md
# Redundant Controller Peer Guard

This block sits beside each of two redundant controller cores that share one control output. Each copy watches the other copy's offline flag. If the partner stays offline for too long, the copy declares a functional-interrupt fault and sends one request to reload the partner's configuration. It keeps driving the shared output while the partner is repaired. When the repaired partner comes back and asks for state, the copy hands over its live control word on a valid/ready stream. The feedback loop therefore never loses its driver.

The same block also covers the receiving side. After its own reset, which marks the end of a reconfiguration, an instance keeps its driver in high impedance and holds `rx_ready` high. It leaves that phase in one of two ways. It can accept a state word from a working partner, or, if the partner is also offline for a start-up window, it comes up alone, as happens at a cold power-up of both copies.

The `MODE` parameter picks the recovery style. In resync mode the received word is loaded into the local core. In reset-both mode the word is discarded and the working side pulses `core_rst` to restart its own core as well. The two instances connect crosswise: `tx_*` of one goes to `rx_*` of the other, and `drv_en` negated serves as the partner's offline flag.

Stream rules: a transfer happens on a rising clock edge where valid and ready are both high. Once `tx_valid` is raised, it stays high and `tx_data` stays constant until `tx_ready` is seen. `rx_ready` is high only while the instance waits for state.

Top module: `redund_peer_guard`

## Requirements
- R1: While `rst_n` is low, `drv_en`, `reconf_req`, `tx_valid`, `state_load_en` and `core_rst` are 0 and `rx_ready` is 1.
- R2: Two conditions apply: the local driver is enabled, and no recovery is in progress. If `peer_offline` is then sampled high on TIMEOUT consecutive rising edges, `reconf_req` is high during the clock cycle that follows the next edge. Shorter runs raise nothing, and the count restarts whenever `peer_offline` is low.
- R3: `reconf_req` is a single-cycle pulse. It is not raised again until the state handshake has completed and `peer_offline` has been sampled low.
- R4: While `drv_en` is low, offline time of the partner is not counted, so no request is raised.
- R5: The stream is checked in two parts:
  - After a request, the first edge with `tx_ready` high captures `core_state`, and `tx_valid` is high in the next cycle with that word on `tx_data`.
  - While `tx_ready` is low, `tx_valid` and `tx_data` hold. After the accepting edge, `tx_valid` is 0.
- R6: `drv_en` of the working instance stays 1 through detection, request, transfer and return to monitoring.
- R7: In reset-both mode, `core_rst` is 1 for exactly the cycle after the accepting edge. In resync mode, `core_rst` never rises.
- R8: After reset, with `peer_offline` low, `drv_en` stays 0 and `rx_ready` stays 1 until `rx_valid` is seen. After that edge:
  - In resync mode, `state_load_en` is 1 for one cycle, with `state_load_data` equal to the received `rx_data`.
  - In reset-both mode, `state_load_en` stays 0.
  - In both modes, `drv_en` rises in the following cycle.
- R9: After reset, if `peer_offline` is sampled high on START_TIMEOUT consecutive edges while waiting, `drv_en` becomes 1 in the cycle after the next edge, without any transfer.
- R10: `self_offline` high forces `drv_en` to 0 in the same cycle.
- R11: Once running, `rx_ready` is 0 and `rx_valid` has no effect; `state_load_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (also applied at end of reconfiguration) |
| self_offline | input | 1 | Local core reports it cannot drive |
| peer_offline | input | 1 | Partner instance is not driving |
| reconf_req | output | 1 | One-cycle request to reload the partner's configuration |
| drv_en | output | 1 | Enable of the local output driver (0 = high impedance) |
| core_state | input | W | Live control state of the local core |
| tx_data | output | W | State word sent to the partner |
| tx_valid | output | 1 | State word valid |
| tx_ready | input | 1 | Partner ready to take state |
| rx_data | input | W | State word from the partner |
| rx_valid | input | 1 | Partner's state word valid |
| rx_ready | output | 1 | Local instance waiting for state |
| state_load_en | output | 1 | Load `state_load_data` into the local core |
| state_load_data | output | W | State word to load |
| core_rst | output | 1 | Restart pulse for the local core in reset-both mode |

## Verification
A wrong offline count shows at `reconf_req`. The pulse appears a cycle early or late against the exact run length of `peer_offline`, or a short run raises a request it should not. A supervisor stuck outside monitoring shows as a missing request on the next fault, or a second request during recovery. A wrong local phase shows at `drv_en` and `rx_ready` within one cycle of a handshake or of the start-up window expiring. A lost snapshot shows on `tx_data` in the first valid cycle.

// File: rtl/redund_pkg.sv
package redund_pkg;
  typedef enum logic [1:0] {
    SUP_MONITOR    = 2'd0,
    SUP_FAULT      = 2'd1,
    SUP_RECFG_WAIT = 2'd2,
    SUP_SYNC       = 2'd3
  } sup_state_e;

  typedef enum logic [1:0] {
    LOC_WAIT = 2'd0,
    LOC_LOAD = 2'd1,
    LOC_RUN  = 2'd2
  } loc_state_e;

  typedef enum logic {
    RECOV_RESET_BOTH = 1'b0,
    RECOV_RESYNC     = 1'b1
  } recov_mode_e;
endpackage

// File: rtl/offline_timer.sv
module offline_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!count_en)     cnt <= '0;
    else if (cnt != LIM)    cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);
endmodule

// File: rtl/peer_supervisor.sv
module peer_supervisor
  import redund_pkg::*;
#(
  parameter int          W       = 8,
  parameter int          TIMEOUT = 16,
  parameter recov_mode_e MODE    = RECOV_RESYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         peer_offline,
  input  logic         local_driving,
  input  logic [W-1:0] core_state,
  input  logic         tx_ready,
  output logic         reconf_req,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  output logic         core_rst
);
  sup_state_e   st, st_nx;
  logic         sent;
  logic         timed_out;
  logic [W-1:0] snap;
  logic         xfer;

  offline_timer #(.LIMIT(TIMEOUT)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (peer_offline && local_driving && (st == SUP_MONITOR)),
    .expired  (timed_out)
  );

  assign xfer = tx_valid && tx_ready;

  always_comb begin
    st_nx = st;
    unique case (st)
      SUP_MONITOR:    if (timed_out) st_nx = SUP_FAULT;
      SUP_FAULT:      st_nx = SUP_RECFG_WAIT;
      SUP_RECFG_WAIT: if (tx_ready) st_nx = SUP_SYNC;
      SUP_SYNC:       if (sent && !peer_offline) st_nx = SUP_MONITOR;
      default:        st_nx = SUP_MONITOR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SUP_MONITOR;
      sent     <= 1'b0;
      snap     <= '0;
      core_rst <= 1'b0;
    end else begin
      st       <= st_nx;
      core_rst <= xfer && (MODE == RECOV_RESET_BOTH);
      if (st == SUP_RECFG_WAIT && tx_ready) snap <= core_state;
      if (st_nx == SUP_MONITOR)             sent <= 1'b0;
      else if (xfer)                        sent <= 1'b1;
    end
  end

  assign reconf_req = (st == SUP_FAULT);
  assign tx_valid   = (st == SUP_SYNC) && !sent;
  assign tx_data    = snap;

  // R3
  reconf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req |=> !reconf_req);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/local_sync.sv
module local_sync
  import redund_pkg::*;
#(
  parameter int          W             = 8,
  parameter int          START_TIMEOUT = 32,
  parameter recov_mode_e MODE          = RECOV_RESYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         self_offline,
  input  logic         peer_offline,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  output logic         rx_ready,
  output logic         drv_en,
  output logic         state_load_en,
  output logic [W-1:0] state_load_data
);
  loc_state_e   ls, ls_nx;
  logic         alone;
  logic [W-1:0] held;

  offline_timer #(.LIMIT(START_TIMEOUT)) u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (peer_offline && (ls == LOC_WAIT)),
    .expired  (alone)
  );

  always_comb begin
    ls_nx = ls;
    unique case (ls)
      LOC_WAIT: if (rx_valid)   ls_nx = LOC_LOAD;
                else if (alone) ls_nx = LOC_RUN;
      LOC_LOAD: ls_nx = LOC_RUN;
      LOC_RUN:  ls_nx = LOC_RUN;
      default:  ls_nx = LOC_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls   <= LOC_WAIT;
      held <= '0;
    end else begin
      ls <= ls_nx;
      if (ls == LOC_WAIT && rx_valid) held <= rx_data;
    end
  end

  assign rx_ready        = (ls == LOC_WAIT);
  assign drv_en          = (ls == LOC_RUN) && !self_offline;
  assign state_load_en   = (ls == LOC_LOAD) && (MODE == RECOV_RESYNC);
  assign state_load_data = held;

  // R8
  load_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !drv_en);
  // R11
  ready_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> !rx_ready);
endmodule

// File: rtl/redund_peer_guard.sv
module redund_peer_guard
  import redund_pkg::*;
#(
  parameter int          W             = 8,
  parameter int          TIMEOUT       = 16,
  parameter int          START_TIMEOUT = 32,
  parameter recov_mode_e MODE          = RECOV_RESYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         self_offline,
  input  logic         peer_offline,
  output logic         reconf_req,
  output logic         drv_en,
  input  logic [W-1:0] core_state,
  output logic [W-1:0] tx_data,
  output logic         tx_valid,
  input  logic         tx_ready,
  input  logic [W-1:0] rx_data,
  input  logic         rx_valid,
  output logic         rx_ready,
  output logic         state_load_en,
  output logic [W-1:0] state_load_data,
  output logic         core_rst
);
  local_sync #(.W(W), .START_TIMEOUT(START_TIMEOUT), .MODE(MODE)) u_local (
    .clk             (clk),
    .rst_n           (rst_n),
    .self_offline    (self_offline),
    .peer_offline    (peer_offline),
    .rx_valid        (rx_valid),
    .rx_data         (rx_data),
    .rx_ready        (rx_ready),
    .drv_en          (drv_en),
    .state_load_en   (state_load_en),
    .state_load_data (state_load_data)
  );

  peer_supervisor #(.W(W), .TIMEOUT(TIMEOUT), .MODE(MODE)) u_sup (
    .clk           (clk),
    .rst_n         (rst_n),
    .peer_offline  (peer_offline),
    .local_driving (drv_en),
    .core_state    (core_state),
    .tx_ready      (tx_ready),
    .reconf_req    (reconf_req),
    .tx_valid      (tx_valid),
    .tx_data       (tx_data),
    .core_rst      (core_rst)
  );

  // R7
  core_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> $past(tx_valid && tx_ready));
endmodule

// File: tb/redund_peer_guard_tb_top.sv
module redund_peer_guard_tb_top;
  import redund_pkg::*;
  localparam int W  = 8;
  localparam int T  = 4;
  localparam int S  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic self_offline = 1'b0, peer_offline = 1'b1;
  logic [W-1:0] core_state = '0, rx_data = '0;
  logic tx_ready = 1'b0, rx_valid = 1'b0;

  logic rq_a, en_a, tv_a, rr_a, le_a, cr_a;
  logic rq_b, en_b, tv_b, rr_b, le_b, cr_b;
  logic [W-1:0] td_a, ld_a, td_b, ld_b;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  redund_peer_guard #(.W(W), .TIMEOUT(T), .START_TIMEOUT(S), .MODE(RECOV_RESYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .self_offline(self_offline), .peer_offline(peer_offline),
    .reconf_req(rq_a), .drv_en(en_a), .core_state(core_state), .tx_data(td_a),
    .tx_valid(tv_a), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rr_a), .state_load_en(le_a), .state_load_data(ld_a), .core_rst(cr_a));

  redund_peer_guard #(.W(W), .TIMEOUT(T), .START_TIMEOUT(S), .MODE(RECOV_RESET_BOTH)) dut_rb_i (
    .clk(clk), .rst_n(rst_n), .self_offline(self_offline), .peer_offline(peer_offline),
    .reconf_req(rq_b), .drv_en(en_b), .core_state(core_state), .tx_data(td_b),
    .tx_valid(tv_b), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rr_b), .state_load_en(le_b), .state_load_data(ld_b), .core_rst(cr_b));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic poff);
    peer_offline = poff;
    rst_n = 1'b0;
    tick();
    // R1 reset state on both instances
    chk("R1", "drv_en", {en_a, en_b}, 0);
    chk("R1", "rx_ready", {rr_a, rr_b}, 3);
    chk("R1", "reconf/tx_valid", {rq_a, rq_b, tv_a, tv_b}, 0);
    chk("R1", "load/core_rst", {le_a, le_b, cr_a, cr_b}, 0);
    rst_n = 1'b1;
  endtask

  // called with both supervisors waiting for tx_ready
  task automatic recover(input logic [W-1:0] val, input int gap);
    core_state = val;
    tx_ready = 1'b1;
    tick();
    chk("R5", "tx_valid first", {tv_a, tv_b}, 3);
    chk("R5", "tx_data snapshot", td_a, val);
    chk("R5", "tx_data snapshot rb", td_b, val);
    core_state = ~val;
    if (gap > 0) begin
      tx_ready = 1'b0;
      for (int g = 0; g < gap; g++) begin
        tick();
        chk("R5", "valid held", {tv_a, tv_b}, 3);
        chk("R5", "data held", td_a, val);
      end
      tx_ready = 1'b1;
    end
    tick();
    chk("R5", "valid dropped", {tv_a, tv_b}, 0);
    chk("R7", "core_rst resync/resetboth", {cr_a, cr_b}, 1);
    chk("R6", "drv_en during sync", {en_a, en_b}, 3);
    tx_ready = 1'b0;
    tick();
    chk("R7", "core_rst single", {cr_a, cr_b}, 0);
    tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    // cold start, R9
    do_reset(1'b1);
    for (int n = 1; n <= S + 1; n++) begin
      tick();
      chk("R9", "cold start drv_en", {en_a, en_b}, (n == S + 1) ? 3 : 0);
    end
    peer_offline = 1'b0;
    // R11 rx ignored once running
    rx_valid = 1'b1; rx_data = 8'h3C;
    for (int n = 0; n < 3; n++) begin
      tick();
      chk("R11", "rx_ready low", {rr_a, rr_b}, 0);
      chk("R11", "no load", {le_a, le_b}, 0);
    end
    rx_valid = 1'b0;
    tick();

    // R2 sweep of offline run lengths
    for (int d = 1; d <= T + 2; d++) begin
      peer_offline = 1'b1;
      pulses = 0;
      for (int n = 1; n <= T + 4; n++) begin
        tick();
        chk("R2", $sformatf("reconf d=%0d n=%0d", d, n), {rq_a, rq_b},
            (d >= T && n == T + 1) ? 3 : 0);
        chk("R6", "drv_en while peer down", {en_a, en_b}, 3);
        if (n == d) peer_offline = 1'b0;
      end
      if (d >= T) recover(8'(8'h11 * d), (d == T + 1) ? 3 : 0);
      tick();
    end

    // R3 no re-request during recovery with partner still offline
    peer_offline = 1'b1;
    pulses = 0;
    for (int n = 0; n < 20; n++) begin
      tick();
      if (rq_a) pulses++;
    end
    chk("R3", "single request while waiting", pulses, 1);
    recover(8'h5A, 2);
    pulses = 0;
    for (int n = 0; n < 8; n++) begin
      tick();
      if (rq_a || rq_b) pulses++;
    end
    chk("R3", "no request in sync hold", pulses, 0);
    peer_offline = 1'b0;
    tick(); tick();

    // R10 and R4
    self_offline = 1'b1;
    #1;
    chk("R10", "drv_en forced low", {en_a, en_b}, 0);
    peer_offline = 1'b1;
    pulses = 0;
    for (int n = 0; n < T + 3; n++) begin
      tick();
      if (rq_a || rq_b) pulses++;
    end
    chk("R4", "no count while not driving", pulses, 0);
    peer_offline = 1'b0;
    self_offline = 1'b0;
    #1;
    chk("R10", "drv_en restored", {en_a, en_b}, 3);
    tick();

    // R8 recovering side: load from working partner
    do_reset(1'b0);
    for (int n = 0; n < S + 4; n++) begin
      tick();
      chk("R8", "held off while partner online", {en_a, en_b}, 0);
      chk("R8", "ready while waiting", {rr_a, rr_b}, 3);
    end
    rx_valid = 1'b1; rx_data = 8'hA5;
    tick();
    rx_valid = 1'b0;
    chk("R8", "load pulse resync/resetboth", {le_a, le_b}, 2);
    chk("R8", "load data", ld_a, 8'hA5);
    chk("R8", "not yet driving", {en_a, en_b}, 0);
    tick();
    chk("R8", "driving after load", {en_a, en_b}, 3);
    chk("R8", "load ended", {le_a, le_b}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule